// File: doc/BRIEF.md
# Cascaded interrupt status encoder

This block gathers interrupt requests from three source groups and reduces them to one 32-bit status word that software reads to learn which source to service. The groups are a critical group of 4 sources, a main group of 17 sources and a peripheral group of 32 sources. Each group has its own disable mask. Each group encodes its lowest-numbered enabled pending source into a present flag and an index, and all three results share the one word.

Peripheral sources can be raised into a higher group. Any enabled pending peripheral in the high-promotion set (parameter `PER_HI_SET`) raises critical source 2. Any in the low-promotion set (`PER_LO_SET`) raises main source 4. When software sees either index, it reads the peripheral field to find the actual source. Peripheral source 0 is fed by a cascaded sub-controller. That sub-controller has its own request vector and mask, and it reports its own winning index on separate outputs.

Masks are written through a small write port: a write strobe, a 2-bit group select and a 32-bit data word. The status word and the sub-controller outputs are registered.

Top module: `pic_status_enc`

## Requirements
- R1: After reset the status word and sub-controller outputs read 0, and the masks hold these values: critical 4'hF, main 0x00010fff, peripheral 0x7ffffc00, sub-controller all ones.
- R2: Status layout: bit 10 is the critical flag with its index in bits 9:8; bit 21 is the main flag with its index in bits 20:16; bit 29 is the peripheral flag with its index in bits 28:24. All other bits are 0.
- R3: Within a group the lowest-numbered enabled pending source wins. A group with nothing enabled and pending shows flag 0 and index 0.
- R4: Main mask bit 16-n disables main source n when 1.
- R5: Peripheral mask bit 31-n disables peripheral source n when 1.
- R6: Critical mask bit n and sub-controller mask bit n each disable source n of their group when 1.
- R7: An enabled pending peripheral in `PER_HI_SET` raises critical source 2, which stays subject to critical mask bit 2. In that case the peripheral index is the lowest enabled pending member of `PER_HI_SET`.
- R8: An enabled pending peripheral in `PER_LO_SET` raises main source 4, which stays subject to main mask bit 4. If no high-set member is pending, the peripheral index is the lowest enabled pending member of `PER_LO_SET`.
- R9: Any enabled pending sub-controller request raises peripheral source 0. `sub_valid_o` and `sub_idx_o` give the lowest enabled pending sub-controller source, or 0 and 0 when there is none.
- R10: Outputs are registered. The status seen after clock edge k reflects the requests and mask contents at edge k. A mask write presented at edge k first affects the status computed at edge k+1.
- R11: Mask select encoding: 0 selects critical (data bits 3:0), 1 selects main (16:0), 2 selects peripheral (31:0), 3 selects sub-controller (SUB_N-1:0). A write changes only the selected mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 4 | Critical group requests |
| main_req_i | input | 17 | Main group requests |
| per_req_i | input | 32 | Peripheral group requests |
| sub_req_i | input | SUB_N | Sub-controller requests |
| mask_we_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 2 | Mask select (R11) |
| mask_wdata_i | input | 32 | Mask write data |
| status_o | output | 32 | Encoded status word |
| sub_valid_o | output | 1 | Sub-controller request present |
| sub_idx_o | output | $clog2(SUB_N) | Sub-controller winning index |

## Verification
A corrupted mask bit shows in the status word one cycle after a request from the affected source is presented. It appears as a missing or extra flag, or as an index that skips to the next source. A wrong promotion decision shows the same cycle as a critical index 2 or main index 4 with no matching peripheral field. The bench runs a behavioural model on every clock, so any such divergence is reported in the first cycle where a request makes it visible.

// File: rtl/pic_status_pkg.sv
`timescale 1ns/1ps
package pic_status_pkg;
  localparam int CRIT_N = 4;
  localparam int MAIN_N = 17;
  localparam int PER_N  = 32;
  localparam int CRIT_IW = $clog2(CRIT_N);
  localparam int MAIN_IW = $clog2(MAIN_N);
  localparam int PER_IW  = $clog2(PER_N);
  localparam int CRIT_FLAG_BIT = 10;
  localparam int CRIT_IDX_LSB  = 8;
  localparam int MAIN_FLAG_BIT = 21;
  localparam int MAIN_IDX_LSB  = 16;
  localparam int PER_FLAG_BIT  = 29;
  localparam int PER_IDX_LSB   = 24;
  localparam int CRIT_PROMO_SRC = 2;
  localparam int MAIN_PROMO_SRC = 4;
  localparam int PER_CASCADE_SRC = 0;
  typedef enum logic [1:0] {
    MSEL_CRIT = 2'd0,
    MSEL_MAIN = 2'd1,
    MSEL_PER  = 2'd2,
    MSEL_SUB  = 2'd3
  } mask_sel_e;
endpackage

// File: rtl/pic_mask_reg.sv
`timescale 1ns/1ps
module pic_mask_reg #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit REVERSE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= RST_VAL;
    else if (we_i) mask_q <= wdata_i;
  end

  // source n maps to bit n, or to bit W-1-n when reversed; 1 disables
  generate
    if (REVERSE) begin : g_rev
      for (genvar n = 0; n < W; n++) begin : g_bit
        assign en_o[n] = ~mask_q[W-1-n];
      end
    end else begin : g_fwd
      assign en_o = ~mask_q;
    end
  endgenerate
endmodule

// File: rtl/pic_lowest_enc.sv
`timescale 1ns/1ps
module pic_lowest_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/pic_status_enc.sv
`timescale 1ns/1ps
module pic_status_enc
  import pic_status_pkg::*;
#(
  parameter int SUB_N = 16,
  parameter logic [PER_N-1:0] PER_HI_SET = 32'h0000_0006,
  parameter logic [PER_N-1:0] PER_LO_SET = 32'h0000_0030,
  localparam int SUB_IW = $clog2(SUB_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CRIT_N-1:0] crit_req_i,
  input  logic [MAIN_N-1:0] main_req_i,
  input  logic [PER_N-1:0]  per_req_i,
  input  logic [SUB_N-1:0]  sub_req_i,
  input  logic              mask_we_i,
  input  logic [1:0]        mask_sel_i,
  input  logic [31:0]       mask_wdata_i,
  output logic [31:0]       status_o,
  output logic              sub_valid_o,
  output logic [SUB_IW-1:0] sub_idx_o
);
  logic [CRIT_N-1:0] crit_en;
  logic [MAIN_N-1:0] main_en;
  logic [PER_N-1:0]  per_en;
  logic [SUB_N-1:0]  sub_en;
  mask_sel_e sel;
  assign sel = mask_sel_e'(mask_sel_i);

  pic_mask_reg #(.W(CRIT_N), .RST_VAL({CRIT_N{1'b1}}), .REVERSE(1'b0)) u_crit_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i && sel == MSEL_CRIT),
    .wdata_i(mask_wdata_i[CRIT_N-1:0]), .en_o(crit_en));
  pic_mask_reg #(.W(MAIN_N), .RST_VAL(17'h1_0fff), .REVERSE(1'b1)) u_main_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i && sel == MSEL_MAIN),
    .wdata_i(mask_wdata_i[MAIN_N-1:0]), .en_o(main_en));
  pic_mask_reg #(.W(PER_N), .RST_VAL(32'h7fff_fc00), .REVERSE(1'b1)) u_per_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i && sel == MSEL_PER),
    .wdata_i(mask_wdata_i[PER_N-1:0]), .en_o(per_en));
  pic_mask_reg #(.W(SUB_N), .RST_VAL({SUB_N{1'b1}}), .REVERSE(1'b0)) u_sub_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i && sel == MSEL_SUB),
    .wdata_i(mask_wdata_i[SUB_N-1:0]), .en_o(sub_en));

  // sub-controller cascade
  logic              sub_any;
  logic [SUB_IW-1:0] sub_idx;
  pic_lowest_enc #(.N(SUB_N), .IW(SUB_IW)) u_sub_enc (
    .req_i(sub_req_i & sub_en), .valid_o(sub_any), .idx_o(sub_idx));

  // peripheral group, promoted classes take the index field first
  logic [PER_N-1:0] per_raw, per_pend, hi_pend, lo_pend, per_pick;
  always_comb begin
    per_raw = per_req_i;
    per_raw[PER_CASCADE_SRC] = per_req_i[PER_CASCADE_SRC] | sub_any;
  end
  assign per_pend = per_raw & per_en;
  assign hi_pend  = per_pend & PER_HI_SET;
  assign lo_pend  = per_pend & PER_LO_SET;
  assign per_pick = (|hi_pend) ? hi_pend : ((|lo_pend) ? lo_pend : per_pend);

  logic              per_any;
  logic [PER_IW-1:0] per_idx;
  pic_lowest_enc #(.N(PER_N), .IW(PER_IW)) u_per_enc (
    .req_i(per_pick), .valid_o(per_any), .idx_o(per_idx));

  logic [CRIT_N-1:0] crit_raw;
  logic [MAIN_N-1:0] main_raw;
  always_comb begin
    crit_raw = crit_req_i;
    crit_raw[CRIT_PROMO_SRC] = crit_req_i[CRIT_PROMO_SRC] | (|hi_pend);
    main_raw = main_req_i;
    main_raw[MAIN_PROMO_SRC] = main_req_i[MAIN_PROMO_SRC] | (|lo_pend);
  end

  logic               crit_any, main_any;
  logic [CRIT_IW-1:0] crit_idx;
  logic [MAIN_IW-1:0] main_idx;
  pic_lowest_enc #(.N(CRIT_N), .IW(CRIT_IW)) u_crit_enc (
    .req_i(crit_raw & crit_en), .valid_o(crit_any), .idx_o(crit_idx));
  pic_lowest_enc #(.N(MAIN_N), .IW(MAIN_IW)) u_main_enc (
    .req_i(main_raw & main_en), .valid_o(main_any), .idx_o(main_idx));

  logic [31:0] status_d;
  always_comb begin
    status_d = '0;
    status_d[CRIT_FLAG_BIT] = crit_any;
    status_d[CRIT_IDX_LSB +: CRIT_IW] = crit_idx;
    status_d[MAIN_FLAG_BIT] = main_any;
    status_d[MAIN_IDX_LSB +: MAIN_IW] = main_idx;
    status_d[PER_FLAG_BIT] = per_any;
    status_d[PER_IDX_LSB +: PER_IW] = per_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o    <= '0;
      sub_valid_o <= 1'b0;
      sub_idx_o   <= '0;
    end else begin
      status_o    <= status_d;
      sub_valid_o <= sub_any;
      sub_idx_o   <= sub_idx;
    end
  end
endmodule

// File: rtl/pic_status_enc_chk.sv
`timescale 1ns/1ps
module pic_status_enc_chk #(
  parameter int SUB_N = 16,
  localparam int SUB_IW = $clog2(SUB_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        crit_req_i,
  input logic [16:0]       main_req_i,
  input logic [31:0]       per_req_i,
  input logic [SUB_N-1:0]  sub_req_i,
  input logic [31:0]       status_o,
  input logic              sub_valid_o,
  input logic [SUB_IW-1:0] sub_idx_o
);
  assert_layout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~32'h3f3f_0700) == 32'h0);

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[10] || status_o[9:8] == 2'd0) &&
    (status_o[21] || status_o[20:16] == 5'd0) &&
    (status_o[29] || status_o[28:24] == 5'd0));

  assert_hi_promo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[10] && status_o[9:8] == 2'd2 && !$past(crit_req_i[2])) |-> status_o[29]);

  assert_lo_promo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[21] && status_o[20:16] == 5'd4 && !$past(main_req_i[4])) |-> status_o[29]);

  assert_sub_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_valid_o |-> sub_idx_o == '0);

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(crit_req_i == 4'd0 && main_req_i == 17'd0 && per_req_i == 32'd0 && sub_req_i == '0)
    |-> (status_o == 32'd0 && !sub_valid_o));
endmodule

bind pic_status_enc pic_status_enc_chk #(.SUB_N(SUB_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .crit_req_i(crit_req_i), .main_req_i(main_req_i),
  .per_req_i(per_req_i), .sub_req_i(sub_req_i), .status_o(status_o),
  .sub_valid_o(sub_valid_o), .sub_idx_o(sub_idx_o));

// File: tb/pic_status_enc_tb_top.sv
`timescale 1ns/1ps
module pic_status_enc_tb_top;
  localparam int SUBN = 16;
  localparam logic [31:0] HI = 32'h0000_0006;
  localparam logic [31:0] LO = 32'h0000_0030;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [31:0] per_req = '0;
  logic [SUBN-1:0] sub_req = '0;
  logic mask_we = 1'b0;
  logic [1:0] mask_sel = '0;
  logic [31:0] mask_wdata = '0;
  logic [31:0] status;
  logic sub_valid;
  logic [3:0] sub_idx;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  pic_status_enc #(.SUB_N(SUBN), .PER_HI_SET(HI), .PER_LO_SET(LO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .crit_req_i(crit_req), .main_req_i(main_req),
    .per_req_i(per_req), .sub_req_i(sub_req), .mask_we_i(mask_we),
    .mask_sel_i(mask_sel), .mask_wdata_i(mask_wdata), .status_o(status),
    .sub_valid_o(sub_valid), .sub_idx_o(sub_idx));

  // reference model state (raw mask registers as software sees them)
  bit [3:0]  m_crit;
  bit [16:0] m_main;
  bit [31:0] m_per;
  bit [15:0] m_sub;
  bit [31:0] exp_status;
  bit        exp_sv;
  int        exp_si;

  function automatic int lowest(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit [31:0] pp, hi, lo, cp, mp, sp;
    int pw, cw, mw, sw;
    if (!rst_n) begin
      m_crit = 4'hf; m_main = 17'h1_0fff; m_per = 32'h7fff_fc00; m_sub = 16'hffff;
      exp_status = 0; exp_sv = 0; exp_si = 0;
    end else begin
      sp = 0;
      for (int n = 0; n < SUBN; n++) sp[n] = sub_req[n] && !m_sub[n];
      sw = lowest(sp);
      pp = 0;
      for (int n = 0; n < 32; n++)
        pp[n] = (per_req[n] || (n == 0 && sw >= 0)) && !m_per[31-n];
      hi = pp & HI; lo = pp & LO;
      pw = (hi != 0) ? lowest(hi) : ((lo != 0) ? lowest(lo) : lowest(pp));
      cp = 0;
      for (int n = 0; n < 4; n++) cp[n] = (crit_req[n] || (n == 2 && hi != 0)) && !m_crit[n];
      mp = 0;
      for (int n = 0; n < 17; n++) mp[n] = (main_req[n] || (n == 4 && lo != 0)) && !m_main[16-n];
      cw = lowest(cp); mw = lowest(mp);
      exp_status = 0;
      if (cw >= 0) begin exp_status[10] = 1; exp_status[9:8] = cw[1:0]; end
      if (mw >= 0) begin exp_status[21] = 1; exp_status[20:16] = mw[4:0]; end
      if (pw >= 0) begin exp_status[29] = 1; exp_status[28:24] = pw[4:0]; end
      exp_sv = (sw >= 0);
      exp_si = (sw >= 0) ? sw : 0;
      if (mask_we) begin
        case (mask_sel)
          2'd0: m_crit = mask_wdata[3:0];
          2'd1: m_main = mask_wdata[16:0];
          2'd2: m_per  = mask_wdata;
          default: m_sub = mask_wdata[15:0];
        endcase
      end
    end
  end

  // compare every clock, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      checks++;
      if (status !== exp_status) begin
        errors++;
        $display("FAIL %s status actual=%h expected=%h", tag, status, exp_status);
      end
      checks++;
      if (sub_valid !== exp_sv || int'(sub_idx) != exp_si) begin
        errors++;
        $display("FAIL %s sub actual=%0b/%0d expected=%0b/%0d", tag, sub_valid, sub_idx, exp_sv, exp_si);
      end
    end
  end

  task automatic expect_lit(logic [31:0] v, string t);
    @(posedge clk); #6;
    checks++;
    if (status !== v) begin
      errors++;
      $display("FAIL %s literal status actual=%h expected=%h", t, status, v);
    end
  endtask

  task automatic wr_mask(logic [1:0] s, logic [31:0] d);
    @(negedge clk); mask_we = 1; mask_sel = s; mask_wdata = d;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic drive(logic [3:0] c, logic [16:0] m, logic [31:0] p, logic [15:0] s);
    @(negedge clk); crit_req = c; main_req = m; per_req = p; sub_req = s;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (status !== 0 || sub_valid !== 0) begin
      errors++; $display("FAIL R1 reset status actual=%h expected=0", status);
    end
    rst_n = 1;
    // R1: reset masks enable main 1..4 and peripheral 0, 22..31
    tag = "R1";
    drive(4'hf, 17'h0_0009, 32'h8000_0006, 16'h0);
    expect_lit(32'h3f23_0000, "R1");
    drive(0, 0, 0, 0);
    expect_lit(32'h0, "R3");
    // R4 and R11: main mask, reversed bit order
    tag = "R4";
    wr_mask(2'd1, 32'h0);
    drive(0, 17'h1_0000, 0, 0);
    expect_lit(32'h0030_0000, "R4");
    drive(0, 17'h1_0100, 0, 0);
    wr_mask(2'd1, 32'h0000_00ff);   // disables main 9..16
    drive(0, 17'h1_0600, 0, 0);
    drive(0, 17'h0_0001, 0, 0);
    // R5: peripheral mask
    tag = "R5";
    wr_mask(2'd2, 32'h0);
    drive(0, 0, 32'h0010_0000, 0);
    expect_lit(32'h3400_0000, "R5");
    wr_mask(2'd2, 32'h0000_0800);   // disables peripheral 20
    drive(0, 0, 32'h0030_0000, 0);
    // R6: critical and sub masks
    tag = "R6";
    wr_mask(2'd0, 32'h0000_0001);
    drive(4'b1011, 0, 0, 0);
    expect_lit(32'h0000_0500, "R6");
    wr_mask(2'd3, 32'h0000_fff0);
    drive(0, 0, 0, 16'h0030);
    drive(0, 0, 0, 16'h000c);
    // R7: high promotion beats lower plain index
    tag = "R7";
    wr_mask(2'd0, 32'h0);
    drive(4'b0000, 0, 32'h0000_0005, 0);
    expect_lit(32'h2200_0600, "R7");
    drive(4'b0001, 0, 32'h0000_0015, 0);
    wr_mask(2'd0, 32'h0000_0004);   // crit source 2 disabled
    drive(0, 0, 32'h0000_0004, 0);
    // R8: low promotion into main 4
    tag = "R8";
    wr_mask(2'd1, 32'h0);
    drive(0, 0, 32'h0000_0028, 0);
    expect_lit(32'h2524_0000, "R8");
    wr_mask(2'd1, 32'h0000_1000);   // main source 4 disabled
    drive(0, 0, 32'h0000_0028, 0);
    // R9: sub-controller cascades into peripheral 0
    tag = "R9";
    wr_mask(2'd3, 32'h0);
    drive(0, 0, 0, 16'h8400);
    expect_lit(32'h2000_0000, "R9");
    wr_mask(2'd2, 32'h8000_0000);   // peripheral 0 disabled
    drive(0, 0, 0, 16'h0002);
    // R10: mask write timing, request held while mask toggles
    tag = "R10";
    wr_mask(2'd2, 32'h0);
    drive(0, 0, 32'h0000_0100, 0);
    wr_mask(2'd2, 32'h0080_0000);
    wr_mask(2'd2, 32'h0);
    // R3/R11: random traffic with random mask writes
    tag = "R3";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      crit_req = 4'($urandom); main_req = 17'($urandom) & 17'($urandom);
      per_req = $urandom & $urandom & $urandom; sub_req = 16'($urandom) & 16'($urandom);
      mask_we = ($urandom % 6 == 0); mask_sel = 2'($urandom);
      mask_wdata = $urandom | $urandom;
    end
    @(negedge clk); mask_we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule